// File: doc/BRIEF.md
# Low-Transition Scan Pattern Generator

This block feeds the serial input of a scan chain during logic built-in self-test. A maximal-length linear feedback shift register supplies pseudorandom state. A small AND gate looks at a few chosen stages of that state, each one taken either as is or inverted. The AND result is the toggle input of a T flip-flop, and the flip-flop output is the bit shifted into the chain. The output changes only when every selected tap agrees, so runs of equal values reach neighbouring scan cells. This cuts switching during scan shift compared with feeding the register bit straight into the chain.

The register advances only while shift enable is high. A synchronous seed load starts a new pattern sequence. An elaboration parameter can put a bit-swapping view of the register in front of the taps. In that view, adjacent stage pairs are exchanged whenever the most significant stage is 1.

Top module: `ltscan_gen`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, `scan_bit` is 0 and the register holds `RESET_SEED`. The reset is released to the logic through a two-stage synchronizer.
- R2: When `seed_load` is 1 at a clock edge, the register takes `seed_value` and `scan_bit` becomes 0 after that edge. This happens whatever the value of `shift_en`.
- R3: A `seed_value` of zero loads 1 instead, so the register never holds the all-zero state.
- R4: With the default width 8, each advance shifts the register left and places bit7^bit5^bit4^bit3 into bit 0, which is the polynomial x^8+x^6+x^5+x^4+1. The sequence period is 255.
- R5: The gate is the AND of K inputs, with K set to 2 or 3. Input k is stage `TAPk` of the tap view, inverted when bit k of `INV_MASK` is 1. The defaults are K=2, TAP0=1, TAP1=6 and INV_MASK=001, so the gate is ~v[1] & v[6].
- R6: On a clock edge with `shift_en`=1 and no load, `scan_bit` inverts if the gate is 1 and holds if it is 0. The register advances on the same edge.
- R7: On an edge with `shift_en`=0 and no load, both the register and `scan_bit` keep their values.
- R8: Over one full register period of 255 shifts, `scan_bit` makes fewer transitions than the register's top stage, which makes 128.
- R9: With `SWAP_MODE`=1, the tap view swaps bits (0,1), (2,3) and (4,5) when bit 7 is 1. Otherwise it equals the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Synchronous seed load; clears the toggle output |
| seed_value | input | WIDTH | Seed loaded on `seed_load` |
| shift_en | input | 1 | Advances the generator by one bit |
| scan_bit | output | 1 | Serial bit to the scan chain input |

## Verification
The bench drives three instances from the same stimulus: the default K=2 gate, a K=3 gate with mixed inversion, and the bit-swapping view. It compares every output bit with a model built from the recurrence and gate formulas. A zero seed is covered, because a design that took it literally would stall with a constant output. A load issued together with shift enable is covered, because a design that gave shifting priority would produce a different stream from then on. Paused shifting is covered, because a design that advanced while paused would fall out of step with the model. An asynchronous reset in mid-run is covered, because a design whose reset waited for a clock edge would not show 0 at once. A full period is also counted, and a generator that passed the register bit through directly would show 128 transitions instead of far fewer.

// File: rtl/ltscan_pkg.sv
package ltscan_pkg;

  typedef enum logic [0:0] {
    VIEW_PLAIN = 1'b0,
    VIEW_SWAP  = 1'b1
  } view_mode_e;

  localparam int unsigned MAX_K = 3;

endpackage

// File: rtl/ltscan_rst_sync.sv
module ltscan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/ltscan_lfsr.sv
module ltscan_lfsr #(
  parameter int unsigned WIDTH      = 8,
  parameter logic [WIDTH-1:0] FB_MASK    = 8'hB8,
  parameter logic [WIDTH-1:0] RESET_SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             adv,
  output logic [WIDTH-1:0] state
);

  localparam logic [WIDTH-1:0] ONE_SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             fb_bit;
  logic [WIDTH-1:0] safe_seed;

  // zero seed would lock the register, substitute a one
  assign safe_seed = (seed == '0) ? ONE_SEED : seed;
  assign fb_bit    = ^(state_q & FB_MASK);

  always_comb begin
    state_d = state_q;
    if (load) begin
      state_d = safe_seed;
    end else if (adv) begin
      state_d = {state_q[WIDTH-2:0], fb_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/ltscan_view.sv
module ltscan_view
  import ltscan_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter view_mode_e  MODE  = VIEW_PLAIN
) (
  input  logic [WIDTH-1:0] state,
  output logic [WIDTH-1:0] view
);

  localparam int unsigned NPAIRS = (WIDTH - 1) / 2;

  generate
    if (MODE == VIEW_SWAP) begin : g_swap
      always_comb begin
        view = state;
        if (state[WIDTH-1]) begin
          for (int p = 0; p < NPAIRS; p++) begin
            view[2*p]   = state[2*p+1];
            view[2*p+1] = state[2*p];
          end
        end
      end
    end else begin : g_plain
      assign view = state;
    end
  endgenerate

endmodule

// File: rtl/ltscan_gate.sv
module ltscan_gate
  import ltscan_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned K        = 2,
  parameter int unsigned TAP0     = 1,
  parameter int unsigned TAP1     = 6,
  parameter int unsigned TAP2     = 3,
  parameter logic [MAX_K-1:0] INV_MASK = 3'b001
) (
  input  logic [WIDTH-1:0] view,
  output logic             gate
);

  localparam int unsigned TAPS [MAX_K] = '{TAP0, TAP1, TAP2};

  logic [K-1:0] lit;

  generate
    for (genvar k = 0; k < K; k++) begin : g_lit
      if (INV_MASK[k]) begin : g_inv
        assign lit[k] = ~view[TAPS[k]];
      end else begin : g_true
        assign lit[k] = view[TAPS[k]];
      end
    end
  endgenerate

  assign gate = &lit;

endmodule

// File: rtl/ltscan_tff.sv
module ltscan_tff (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic t,
  output logic q
);

  logic q_q;
  logic q_d;

  always_comb begin
    q_d = q_q;
    if (clr) begin
      q_d = 1'b0;
    end else if (en && t) begin
      q_d = ~q_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/ltscan_gen.sv
module ltscan_gen
  import ltscan_pkg::*;
#(
  parameter int unsigned      WIDTH      = 8,
  parameter logic [WIDTH-1:0] FB_MASK    = 8'hB8,
  parameter logic [WIDTH-1:0] RESET_SEED = 8'h01,
  parameter int unsigned      K          = 2,
  parameter int unsigned      TAP0       = 1,
  parameter int unsigned      TAP1       = 6,
  parameter int unsigned      TAP2       = 3,
  parameter logic [MAX_K-1:0] INV_MASK   = 3'b001,
  parameter view_mode_e       SWAP_MODE  = VIEW_PLAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_value,
  input  logic             shift_en,
  output logic             scan_bit
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] lfsr_state;
  logic [WIDTH-1:0] tap_view;
  logic             and_out;

  ltscan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ltscan_lfsr #(
    .WIDTH      (WIDTH),
    .FB_MASK    (FB_MASK),
    .RESET_SEED (RESET_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (seed_load),
    .seed  (seed_value),
    .adv   (shift_en),
    .state (lfsr_state)
  );

  ltscan_view #(
    .WIDTH (WIDTH),
    .MODE  (SWAP_MODE)
  ) u_view (
    .state (lfsr_state),
    .view  (tap_view)
  );

  ltscan_gate #(
    .WIDTH    (WIDTH),
    .K        (K),
    .TAP0     (TAP0),
    .TAP1     (TAP1),
    .TAP2     (TAP2),
    .INV_MASK (INV_MASK)
  ) u_gate (
    .view (tap_view),
    .gate (and_out)
  );

  ltscan_tff u_tff (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (seed_load),
    .en    (shift_en),
    .t     (and_out),
    .q     (scan_bit)
  );

endmodule

// File: rtl/ltscan_gen_chk.sv
module ltscan_gen_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             seed_load,
  input logic             shift_en,
  input logic [WIDTH-1:0] lfsr_state,
  input logic             and_out,
  input logic             scan_bit
);

  // R2: a load leaves the toggle output at 0
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seed_load |=> (scan_bit == 1'b0));

  // R3: the register never reaches the locked state
  a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lfsr_state != '0);

  // R6: an enabled shift with the gate open inverts the output
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !seed_load && and_out) |=> (scan_bit != $past(scan_bit)));

  // R6: an enabled shift with the gate closed keeps the output
  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !seed_load && !and_out) |=> $stable(scan_bit));

  // R7: no shift and no load freezes the whole generator
  a_r7_pause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!shift_en && !seed_load) |=> ($stable(lfsr_state) && $stable(scan_bit)));

  // R4: an enabled shift moves the old bits up by one place
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !seed_load) |=> (lfsr_state[WIDTH-1:1] == $past(lfsr_state[WIDTH-2:0])));

endmodule

bind ltscan_gen ltscan_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .seed_load  (seed_load),
  .shift_en   (shift_en),
  .lfsr_state (lfsr_state),
  .and_out    (and_out),
  .scan_bit   (scan_bit)
);

// File: tb/ltscan_gen_bench.sv
module ltscan_gen_bench;
  import ltscan_pkg::*;

  localparam int NI = 3;
  localparam int KCFG [NI] = '{2, 3, 2};
  localparam int T0 [NI] = '{1, 1, 1};
  localparam int T1 [NI] = '{6, 6, 6};
  localparam int T2 [NI] = '{3, 3, 3};
  localparam logic [2:0] INV [NI] = '{3'b001, 3'b101, 3'b001};
  localparam logic SWP [NI] = '{1'b0, 1'b0, 1'b1};

  // stimulus table: seed, cycle count, enable period (1 = always on)
  localparam int NV = 5;
  localparam logic [7:0] V_SEED [NV] = '{8'h01, 8'hA5, 8'h00, 8'hFF, 8'h5A};
  localparam int V_CYC [NV] = '{20, 30, 15, 25, 40};
  localparam int V_PER [NV] = '{1, 3, 1, 2, 1};

  logic       clk;
  logic       rst_n;
  logic       seed_load;
  logic [7:0] seed_value;
  logic       shift_en;
  logic [NI-1:0] sb;

  int checks;
  int errors;
  logic [7:0] ms [NI];
  logic       mq [NI];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  ltscan_gen u_ltscan_gen (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .shift_en(shift_en), .scan_bit(sb[0])
  );

  ltscan_gen #(.K(3), .INV_MASK(3'b101)) u_ltscan_gen_k3 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .shift_en(shift_en), .scan_bit(sb[1])
  );

  ltscan_gen #(.SWAP_MODE(VIEW_SWAP)) u_ltscan_gen_bs (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .shift_en(shift_en), .scan_bit(sb[2])
  );

  function automatic logic [7:0] nxt(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic gate_of(input int i, input logic [7:0] s);
    logic [7:0] v;
    int tp [3];
    logic g;
    v = s;
    if (SWP[i] && s[7]) begin
      v = {s[7], s[6], s[4], s[5], s[2], s[3], s[0], s[1]};
    end
    tp[0] = T0[i]; tp[1] = T1[i]; tp[2] = T2[i];
    g = 1'b1;
    for (int k = 0; k < KCFG[i]; k++) begin
      g = g & (v[tp[k]] ^ INV[i][k]);
    end
    return g;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    for (int i = 0; i < NI; i++) check(req, sb[i], mq[i]);
  endtask

  // one clock: inputs set at negedge, model advanced, outputs sampled at next negedge
  task automatic step(input logic ld, input logic [7:0] sd, input logic en);
    seed_load  = ld;
    seed_value = sd;
    shift_en   = en;
    for (int i = 0; i < NI; i++) begin
      if (ld) begin
        ms[i] = (sd == 8'h00) ? 8'h01 : sd;
        mq[i] = 1'b0;
      end else if (en) begin
        mq[i] = mq[i] ^ gate_of(i, ms[i]);
        ms[i] = nxt(ms[i]);
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5 * 20000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    seed_load = 1'b0;
    seed_value = 8'h00;
    shift_en = 1'b0;
    for (int i = 0; i < NI; i++) begin ms[i] = 8'h01; mq[i] = 1'b0; end
    repeat (3) @(negedge clk);
    cmp_all("R1 reset value");
    rst_n = 1'b1;
    repeat (4) step(1'b0, 8'h00, 1'b0);
    // R1: the sequence after reset starts from RESET_SEED
    for (int c = 0; c < 20; c++) begin
      step(1'b0, 8'h00, 1'b1);
      cmp_all("R1 R4 R5 R6 stream from reset seed");
    end

    // table walk: R2 load, R3 zero seed, R4..R7 stream under varied enables, R9 swap view
    for (int v = 0; v < NV; v++) begin
      step(1'b1, V_SEED[v], 1'b0);
      cmp_all("R2 load clears output");
      for (int c = 0; c < V_CYC[v]; c++) begin
        step(1'b0, 8'h00, (c % V_PER[v]) == 0);
        cmp_all((V_SEED[v] == 8'h00) ? "R3 zero seed stream" : "R4 R5 R6 R7 R9 stream");
      end
    end

    // R2: load together with shift enable, load wins
    for (int c = 0; c < 7; c++) step(1'b0, 8'h00, 1'b1);
    step(1'b1, 8'h3C, 1'b1);
    cmp_all("R2 load over shift");
    for (int c = 0; c < 12; c++) begin
      step(1'b0, 8'h00, 1'b1);
      cmp_all("R2 stream after load over shift");
    end

    // R7: long pause, outputs held, then stream resumes in step
    for (int c = 0; c < 10; c++) begin
      step(1'b0, 8'h00, 1'b0);
      cmp_all("R7 pause holds");
    end
    for (int c = 0; c < 15; c++) begin
      step(1'b0, 8'h00, 1'b1);
      cmp_all("R7 resume after pause");
    end

    // R8: one full period, count transitions against the raw top stage
    begin
      int lt_cnt [NI];
      int raw_cnt;
      logic prev_sb [NI];
      logic prev_raw;
      step(1'b1, 8'h01, 1'b0);
      raw_cnt = 0;
      prev_raw = ms[0][7];
      for (int i = 0; i < NI; i++) begin lt_cnt[i] = 0; prev_sb[i] = sb[i]; end
      for (int c = 0; c < 255; c++) begin
        step(1'b0, 8'h00, 1'b1);
        if (ms[0][7] != prev_raw) raw_cnt++;
        prev_raw = ms[0][7];
        for (int i = 0; i < NI; i++) begin
          if (sb[i] != prev_sb[i]) lt_cnt[i]++;
          prev_sb[i] = sb[i];
        end
        cmp_all("R8 full period stream");
      end
      checks++;
      if (raw_cnt != 128) begin
        errors++;
        $display("FAIL R8 raw transitions actual %0d expected 128", raw_cnt);
      end
      for (int i = 0; i < NI; i++) begin
        checks++;
        if (lt_cnt[i] >= raw_cnt) begin
          errors++;
          $display("FAIL R8 instance %0d transitions actual %0d expected below %0d", i, lt_cnt[i], raw_cnt);
        end
      end
      // R4: period 255 brings the register back to seed 1
      checks++;
      if (ms[0] != 8'h01) begin
        errors++;
        $display("FAIL R4 period actual %0h expected 01", ms[0]);
      end
    end

    // R1: asynchronous reset in mid-run forces 0 without waiting for an edge
    for (int c = 0; c < 9; c++) step(1'b0, 8'h00, 1'b1);
    #1;
    rst_n = 1'b0;
    #0.5;
    for (int i = 0; i < NI; i++) begin ms[i] = 8'h01; mq[i] = 1'b0; end
    cmp_all("R1 asynchronous reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 8'h00, 1'b0);
    cmp_all("R1 held through sync release");
    for (int c = 0; c < 20; c++) begin
      step(1'b0, 8'h00, 1'b1);
      cmp_all("R1 restart from reset seed");
    end

    finish_run();
  end

endmodule